// File: doc/BRIEF.md
# Spread-Spectrum Tick Divider

The block divides a fast reference clock down to the tick that advances a PWM counter. A 3-bit rate select picks one of eight nominal tick rates. The reference frequency is a parameter, and every divisor, deviation and step interval is computed from it at elaboration time. The output is a pulse one reference cycle wide, one pulse per divided period.

With spreading enabled, the divisor is not held constant. A signed offset is added to it, and that offset traces a triangle: it rises from zero to the positive limit, falls to the negative limit, and climbs back, once per sweep period. A 2-bit field sets the depth of the sweep and another 2-bit field sets its period. This spreads the switching energy of downstream PWM outputs across a band of frequencies. Any change to any select input brings the sweep back to its nominal point at the next tick.

Top module: `ssdiv_top`

## Requirements
- R1: While rst_ni is low, tick_o is low.
- R2: tick_o is high for exactly one reference cycle per divided period. This holds whenever REF_HZ is at least 32 MHz.
- R3: With spreading disabled, successive tick_o pulses are spaced by the nominal divisor nom = max(1, floor(REF_HZ / rate)). The rate depends on freq_sel_i: 0 gives 16 MHz, 1 gives 8 MHz, 2 gives 1 MHz, 3 gives 500 kHz, 4 gives 250 kHz, 5 gives 125 kHz, 6 gives 62.5 kHz and 7 gives 31.25 kHz.
- R4: When spread_en_i is low, range_sel_i and cycle_sel_i have no effect, and the spacing stays at nom.
- R5: With spreading enabled, the deviation limit is dev = floor(nom * p / 100). The percentage p depends on range_sel_i: 0 gives 5, 1 gives 15, 2 gives 24 and 3 gives 34. Every spacing lies in [nom-dev, nom+dev], and both limits occur within one sweep period.
- R6: The sweep period is T = REF_HZ * us / 1e6 reference cycles. The value us depends on cycle_sel_i: 0 gives 1980, 1 gives 1200, 2 gives 820 and 3 gives 660. The offset moves by one every floor(T / (4*dev)) cycles (at least 1), starting upward from zero at the restart tick. A divisor is loaded at each tick from the offset held at that moment.
- R7: After any change to freq_sel_i, spread_en_i, range_sel_i or cycle_sel_i, the first tick restarts the sweep. The interval beginning at that tick equals the new nom.
- R8: When dev computes to zero, enabling spreading leaves the spacing at exactly nom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_sel_i | input | 3 | Nominal tick rate select |
| spread_en_i | input | 1 | Enables the triangular divisor sweep |
| range_sel_i | input | 2 | Sweep depth select |
| cycle_sel_i | input | 2 | Sweep period select |
| tick_o | output | 1 | Single-cycle divided tick |

## Verification
The bench builds the block with REF_HZ = 32 MHz. At that frequency the nominal divisors run from 2 to 1024 and the sweep periods shrink to between 21120 and 63360 cycles, so every rate code and two complete triangles fit in the run. The two swept configurations are chosen so that each step interval is longer than the largest divided period. Because of that, both extremes of the divisor must appear, and the tick that starts the first extreme interval falls inside one step-wide window that the bench computes exactly. Rate code 0 combined with the widest range gives a zero deviation, which exercises the case where the sweep has no effect.

// File: rtl/ssdiv_pkg.sv
package ssdiv_pkg;

  typedef struct packed {
    logic [2:0] freq;
    logic       en;
    logic [1:0] rng;
    logic [1:0] cyc;
  } ss_cfg_t;

  function automatic longint unsigned rate_hz(int unsigned code);
    case (code)
      0:       return 64'd16_000_000;
      1:       return 64'd8_000_000;
      2:       return 64'd1_000_000;
      3:       return 64'd500_000;
      4:       return 64'd250_000;
      5:       return 64'd125_000;
      6:       return 64'd62_500;
      default: return 64'd31_250;
    endcase
  endfunction

  function automatic longint unsigned dev_pct(int unsigned code);
    case (code)
      0:       return 64'd5;
      1:       return 64'd15;
      2:       return 64'd24;
      default: return 64'd34;
    endcase
  endfunction

  function automatic longint unsigned sweep_us(int unsigned code);
    case (code)
      0:       return 64'd1980;
      1:       return 64'd1200;
      2:       return 64'd820;
      default: return 64'd660;
    endcase
  endfunction

  function automatic longint unsigned nom_div(longint unsigned ref_hz, int unsigned f);
    longint unsigned d;
    d = ref_hz / rate_hz(f);
    return (d == 0) ? 64'd1 : d;
  endfunction

  function automatic longint unsigned dev_max(longint unsigned ref_hz, int unsigned f,
                                              int unsigned r);
    return nom_div(ref_hz, f) * dev_pct(r) / 64'd100;
  endfunction

  function automatic longint unsigned sweep_cycles(longint unsigned ref_hz, int unsigned c);
    return ref_hz * sweep_us(c) / 64'd1_000_000;
  endfunction

  function automatic longint unsigned step_len(longint unsigned ref_hz, int unsigned f,
                                               int unsigned r, int unsigned c);
    longint unsigned dm, s;
    dm = dev_max(ref_hz, f, r);
    if (dm == 0) return 64'd0;
    s = sweep_cycles(ref_hz, c) / (64'd4 * dm);
    return (s == 0) ? 64'd1 : s;
  endfunction

endpackage

// File: rtl/ssdiv_cfg.sv
module ssdiv_cfg #(
  parameter longint unsigned REF_HZ = 64_000_000,
  parameter int unsigned     DIV_W  = 12,
  parameter int unsigned     STEP_W = 17
) (
  input  logic [2:0]        freq_sel_i,
  input  logic [1:0]        range_sel_i,
  input  logic [1:0]        cycle_sel_i,
  output logic [DIV_W-1:0]  nom_o,
  output logic [DIV_W-1:0]  dev_o,
  output logic [STEP_W-1:0] step_o
);
  import ssdiv_pkg::*;

  logic [DIV_W-1:0]  nom_tab  [8];
  logic [DIV_W-1:0]  dev_tab  [8][4];
  logic [STEP_W-1:0] step_tab [8][4][4];

  for (genvar f = 0; f < 8; f++) begin : g_rate
    assign nom_tab[f] = DIV_W'(nom_div(REF_HZ, f));
    for (genvar r = 0; r < 4; r++) begin : g_rng
      assign dev_tab[f][r] = DIV_W'(dev_max(REF_HZ, f, r));
      for (genvar c = 0; c < 4; c++) begin : g_cyc
        assign step_tab[f][r][c] = STEP_W'(step_len(REF_HZ, f, r, c));
      end
    end
  end

  assign nom_o  = nom_tab[freq_sel_i];
  assign dev_o  = dev_tab[freq_sel_i][range_sel_i];
  assign step_o = step_tab[freq_sel_i][range_sel_i][cycle_sel_i];
endmodule

// File: rtl/ssdiv_sweep.sv
module ssdiv_sweep #(
  parameter int unsigned DIV_W  = 12,
  parameter int unsigned STEP_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              restart_i,
  input  logic [DIV_W-1:0]  dev_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [DIV_W-1:0]  off_o
);
  localparam logic signed [DIV_W:0] ONE = (DIV_W+1)'(1);

  logic signed [DIV_W:0] off_q, dev_s, inc, dec;
  logic                  up_q;
  logic [STEP_W-1:0]     tmr_q;
  logic                  step_now;

  assign dev_s    = $signed({1'b0, dev_i});
  assign inc      = off_q + ONE;
  assign dec      = off_q - ONE;
  assign step_now = (tmr_q >= step_i - STEP_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q <= '0;
      up_q  <= 1'b1;
      tmr_q <= '0;
    end else if (!en_i || restart_i || dev_i == '0) begin
      off_q <= '0;
      up_q  <= 1'b1;
      tmr_q <= '0;
    end else if (step_now) begin
      tmr_q <= '0;
      if (up_q) begin
        off_q <= inc;
        if (inc >= dev_s) up_q <= 1'b0;
      end else begin
        off_q <= dec;
        if (dec <= -dev_s) up_q <= 1'b1;
      end
    end else begin
      tmr_q <= tmr_q + STEP_W'(1);
    end
  end

  // two's complement; magnitude always below 2**(DIV_W-1)
  assign off_o = off_q[DIV_W-1:0];
endmodule

// File: rtl/ssdiv_count.sv
module ssdiv_count #(
  parameter int unsigned DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] load_i,
  output logic             wrap_o,
  output logic [DIV_W-1:0] cur_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, div_q;
  logic             tick_q;

  assign wrap_o = (cnt_q >= div_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      div_q  <= DIV_W'(1);
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap_o;
      if (wrap_o) begin
        cnt_q <= '0;
        div_q <= load_i;
      end else begin
        cnt_q <= cnt_q + DIV_W'(1);
      end
    end
  end

  assign cur_o  = div_q;
  assign tick_o = tick_q;
endmodule

// File: rtl/ssdiv_top.sv
module ssdiv_top #(
  parameter longint unsigned REF_HZ = 64_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] freq_sel_i,
  input  logic       spread_en_i,
  input  logic [1:0] range_sel_i,
  input  logic [1:0] cycle_sel_i,
  output logic       tick_o
);
  import ssdiv_pkg::*;

  localparam longint unsigned MAX_DIV  = nom_div(REF_HZ, 7) + dev_max(REF_HZ, 7, 3);
  localparam longint unsigned MAX_STEP = sweep_cycles(REF_HZ, 0);
  localparam int unsigned     DIV_W    = $clog2(MAX_DIV + 1);
  localparam int unsigned     STEP_W   = $clog2(MAX_STEP + 1);

  ss_cfg_t           cfg_w, cfg_q;
  logic              cfg_chg, pend_q, wrap, restart;
  logic [DIV_W-1:0]  nom_div_w, dev_max_w, sweep_off, cur_div, load_div;
  logic [STEP_W-1:0] step_w;

  assign cfg_w   = '{freq: freq_sel_i, en: spread_en_i, rng: range_sel_i, cyc: cycle_sel_i};
  assign cfg_chg = (cfg_w != cfg_q);
  assign restart = wrap & (pend_q | cfg_chg);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cfg_q <= cfg_w;
      if (wrap)         pend_q <= 1'b0;
      else if (cfg_chg) pend_q <= 1'b1;
    end
  end

  ssdiv_cfg #(.REF_HZ(REF_HZ), .DIV_W(DIV_W), .STEP_W(STEP_W)) i_cfg (
    .freq_sel_i (freq_sel_i),
    .range_sel_i(range_sel_i),
    .cycle_sel_i(cycle_sel_i),
    .nom_o      (nom_div_w),
    .dev_o      (dev_max_w),
    .step_o     (step_w)
  );

  ssdiv_sweep #(.DIV_W(DIV_W), .STEP_W(STEP_W)) i_sweep (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (spread_en_i),
    .restart_i(restart),
    .dev_i    (dev_max_w),
    .step_i   (step_w),
    .off_o    (sweep_off)
  );

  // modular add is exact: true sum is always in [1, MAX_DIV]
  assign load_div = (restart || !spread_en_i) ? nom_div_w : nom_div_w + sweep_off;

  ssdiv_count #(.DIV_W(DIV_W)) i_count (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_div),
    .wrap_o(wrap),
    .cur_o (cur_div),
    .tick_o(tick_o)
  );
endmodule

// File: rtl/ssdiv_chk.sv
module ssdiv_chk #(
  parameter int unsigned DIV_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_o,
  input logic             spread_en_i,
  input logic             wrap_i,
  input logic             restart_i,
  input logic             pend_i,
  input logic             chg_i,
  input logic [DIV_W-1:0] nom_i,
  input logic [DIV_W-1:0] dev_i,
  input logic [DIV_W-1:0] off_i,
  input logic [DIV_W-1:0] cur_i
);
  logic seen_q;
  logic stable;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (wrap_i) seen_q <= 1'b1;
  end

  assign stable = seen_q && !pend_i && !chg_i;

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) reset_quiet_chk: assert (!tick_o);
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);

  // R4
  off_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!spread_en_i && $past(!spread_en_i)) |-> off_i == '0);

  // R4
  nominal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && !spread_en_i && !pend_i && !chg_i) |=> cur_i == $past(nom_i));

  // R5
  div_bounds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable |-> ({1'b0, cur_i} + {1'b0, dev_i} >= {1'b0, nom_i}) &&
               ({1'b0, cur_i} <= {1'b0, nom_i} + {1'b0, dev_i}));

  // R6
  off_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable |-> ($signed(off_i) <= $signed({1'b0, dev_i})) &&
               ($signed(off_i) >= -$signed({1'b0, dev_i})));

  // R7
  restart_nominal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> cur_i == $past(nom_i));
endmodule

bind ssdiv_top ssdiv_chk #(.DIV_W(DIV_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_o     (tick_o),
  .spread_en_i(spread_en_i),
  .wrap_i     (wrap),
  .restart_i  (restart),
  .pend_i     (pend_q),
  .chg_i      (cfg_chg),
  .nom_i      (nom_div_w),
  .dev_i      (dev_max_w),
  .off_i      (sweep_off),
  .cur_i      (cur_div)
);

// File: tb/test_ssdiv_top.sv
module test_ssdiv_top;
  localparam longint REF = 32_000_000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] freq_sel_i = '0;
  logic       spread_en_i = 1'b0;
  logic [1:0] range_sel_i = '0;
  logic [1:0] cycle_sel_i = '0;
  logic       tick_o;

  longint cyc = 0;
  int     errors = 0;
  int     checks = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  ssdiv_top #(.REF_HZ(REF)) i_ssdiv_top (
    .clk_i, .rst_ni, .freq_sel_i, .spread_en_i, .range_sel_i, .cycle_sel_i, .tick_o
  );

  function automatic longint exp_nom(int f);
    longint rates [8] = '{16_000_000, 8_000_000, 1_000_000, 500_000,
                          250_000, 125_000, 62_500, 31_250};
    longint d = REF / rates[f];
    return (d < 1) ? 1 : d;
  endfunction

  function automatic longint exp_dev(int f, int r);
    longint pct [4] = '{5, 15, 24, 34};
    return exp_nom(f) * pct[r] / 100;
  endfunction

  function automatic longint exp_period(int c);
    longint us [4] = '{1980, 1200, 820, 660};
    return REF * us[c] / 1_000_000;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_tick(output longint t);
    do @(negedge clk_i); while (!tick_o);
    t = cyc;
  endtask

  task automatic set_cfg(int f, bit e, int r, int c);
    freq_sel_i  = 3'(f);
    spread_en_i = e;
    range_sel_i = 2'(r);
    cycle_sel_i = 2'(c);
  endtask

  task automatic run_sweep(int f, int r, int c);
    longint nom = exp_nom(f);
    longint dm  = exp_dev(f, r);
    longint per = exp_period(c);
    longint st  = per / (4 * dm);
    longint t0, t, prev, len, s, mn, mx, fmax, fmin;
    int bad;
    set_cfg(f, 1'b1, r, c);
    get_tick(t0);
    prev = t0; mn = 1 << 30; mx = 0; fmax = -1; fmin = -1; bad = 0;
    get_tick(t);
    chk((t - t0) == nom, "R7 restart interval", t - t0, nom);
    while (prev - t0 < per + 2 * (nom + dm)) begin
      if (prev != t0) get_tick(t);
      len = t - prev;
      s   = prev - t0;
      if (len < nom - dm || len > nom + dm) bad++;
      if (len > mx) mx = len;
      if (len < mn) mn = len;
      if (len == nom + dm && fmax < 0) fmax = s;
      if (len == nom - dm && fmin < 0) fmin = s;
      prev = t;
    end
    chk(bad == 0, "R5 intervals in range", bad, 0);
    chk(mx == nom + dm, "R5 max interval", mx, nom + dm);
    chk(mn == nom - dm, "R5 min interval", mn, nom - dm);
    chk(fmax > dm * st && fmax <= (dm + 1) * st, "R6 max timing", fmax, dm * st + 1);
    chk(fmin > 3 * dm * st && fmin <= (3 * dm + 1) * st, "R6 min timing", fmin,
        3 * dm * st + 1);
  endtask

  initial begin : watchdog
    wait (cyc > 190_000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190_000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    longint t0, t1, t2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(tick_o == 1'b0, "R1 reset quiet", tick_o, 0);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 / R4 / R7: every rate code, spread off, range and cycle fields set
    for (int f = 0; f < 8; f++) begin
      set_cfg(f, 1'b0, 3, 3);
      get_tick(t0);
      get_tick(t1);
      chk((t1 - t0) == exp_nom(f), "R7 first interval", t1 - t0, exp_nom(f));
      for (int k = 0; k < 2; k++) begin
        get_tick(t2);
        chk((t2 - t1) == exp_nom(f), "R3 R4 nominal spacing", t2 - t1, exp_nom(f));
        t1 = t2;
      end
    end

    // R8: deviation rounds to zero for code 0
    begin
      int bad = 0;
      set_cfg(0, 1'b1, 3, 3);
      get_tick(t0);
      for (int k = 0; k < 40; k++) begin
        get_tick(t1);
        if ((t1 - t0) != exp_nom(0)) bad++;
        t0 = t1;
      end
      chk(bad == 0, "R8 zero deviation", bad, 0);
    end

    // R2: single-cycle pulse seen at ports
    begin
      get_tick(t0);
      @(negedge clk_i);
      chk(tick_o == 1'b0, "R2 single cycle", tick_o, 0);
    end

    run_sweep(4, 3, 0);
    run_sweep(3, 3, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule